// File: doc/BRIEF.md
# Low-Speed Time Base Divider

This block divides a slow clock of about 32.768 kHz into a chain of power-of-two rates. It runs a 15-bit binary counter that advances once per falling edge of the slow clock. The upper nine counter bits are the rate taps, from 256 Hz at bit 6 to 1 Hz at bit 14. Every counter bit is brought out, so peripherals can use any divided rate as a clock enable. Four of the taps raise one-cycle interrupt request pulses when they fall.

All logic runs in the system clock domain. The slow clock is synchronised, and its falling edges become single-cycle count steps. A register port lets software read the eight taps from 128 Hz to 1 Hz as one byte. A write strobe on the same port clears those eight taps and carries no data. A tap that drops because of that clear raises its interrupt exactly as a tap that drops by counting.

Top module: `lowspeed_timebase`

## Requirements
- R1: While `rst_ni` is low, `div_o`, `irq_o` and `rdata_o` are all zero.
- R2: The counter is on `div_o`. It advances by exactly one per falling edge of `lsclk_i`. The change appears at the rising `clk_i` edge two cycles after the first edge that samples `lsclk_i` low after a high sample. It is otherwise unchanged, except for the clear in R5.
- R3: Bit k of `div_o` is the counter bit whose rate is 32768/2^(k+1) Hz. Bit 6 is the 256 Hz tap, bit 7 is 128 Hz and bit 14 is 1 Hz.
- R4: A `clk_i` edge with `re_i` high loads `rdata_o` with `div_o[14:7]`, with the 1 Hz tap in bit 7 and the 128 Hz tap in bit 0. `rdata_o` holds its value on edges where `re_i` is low.
- R5: A `clk_i` edge with `we_i` high forces `div_o[14:7]` to zero. Bits 6:0 keep counting, and any carry out of bit 6 on that edge is lost.
- R6: The interrupt map is `irq_o[0]` = 128 Hz (bit 7), `irq_o[1]` = 32 Hz (bit 9), `irq_o[2]` = 16 Hz (bit 10) and `irq_o[3]` = 2 Hz (bit 13). Each pulse is high for exactly the one cycle after its tap goes from 1 to 0.
- R7: A tap that goes from 1 to 0 because of the write clear of R5 raises its interrupt pulse in the next cycle.
- R8: The counter wraps from 0x7FFF to 0x0000 on the step that follows 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lsclk_i | input | 1 | Slow clock, about 32.768 kHz, asynchronous to `clk_i` |
| we_i | input | 1 | Register write strobe; clears taps 128 Hz..1 Hz |
| re_i | input | 1 | Register read strobe |
| rdata_o | output | 8 | Read data: taps 1 Hz (bit 7) down to 128 Hz (bit 0) |
| div_o | output | 15 | Full divider chain, usable as rate enables |
| irq_o | output | 4 | Falling-edge interrupt pulses of the 128, 32, 16 and 2 Hz taps |

## Verification
Two situations are hard to reach from the ports. The first is a clear that lands while a tap is high: the stimulus waits, under its own model of the counter, until the 128 Hz tap is set and then strobes a write, so the clear itself makes the interrupt. The second is the full wrap of the counter, which needs 32768 slow-clock edges after the last clear. The bench therefore runs the slow clock at a quarter of the system rate and leaves a long write-free stretch.

// File: rtl/lstb_pkg.sv
package lstb_pkg;
  localparam int unsigned CNT_W   = 15;
  localparam int unsigned CLR_LSB = 7;
  localparam int unsigned RD_W    = CNT_W - CLR_LSB;
  localparam int unsigned IRQ_N   = 4;
  localparam int unsigned SYNC_N  = 2;
  localparam int unsigned IRQ_BIT [IRQ_N] = '{7, 9, 10, 13};
endpackage

// File: rtl/lstb_fall_sync.sv
module lstb_fall_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lsclk_i,
  output logic fall_o
);
  localparam int unsigned W = SYNC_N + 1;
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[W-2:0], lsclk_i};
  end

  // last stage is the previous synced value
  assign fall_o = sh_q[W-1] & ~sh_q[W-2];
endmodule

// File: rtl/lstb_divider.sv
module lstb_divider #(
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned CLR_LSB = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned HI_W = CNT_W - CLR_LSB;
  logic [CNT_W-1:0]   cnt_q;
  logic [CLR_LSB-1:0] low_nx;

  assign low_nx = cnt_q[CLR_LSB-1:0] + {{(CLR_LSB-1){1'b0}}, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= {{HI_W{1'b0}}, low_nx};
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lstb_fall_irq.sv
module lstb_fall_irq
  import lstb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [IRQ_N-1:0] irq_o
);
  logic [IRQ_N-1:0] prev_q;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= cnt_i[IRQ_BIT[g]];
    end
    assign irq_o[g] = prev_q[g] & ~cnt_i[IRQ_BIT[g]];
  end
endmodule

// File: rtl/lowspeed_timebase.sv
module lowspeed_timebase
  import lstb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lsclk_i,
  input  logic             we_i,
  input  logic             re_i,
  output logic [RD_W-1:0]  rdata_o,
  output logic [CNT_W-1:0] div_o,
  output logic [IRQ_N-1:0] irq_o
);
  logic            step;
  logic [RD_W-1:0] rd_q;

  lstb_fall_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .lsclk_i, .fall_o(step)
  );

  lstb_divider #(.CNT_W(CNT_W), .CLR_LSB(CLR_LSB)) u_div (
    .clk_i, .rst_ni, .step_i(step), .clr_i(we_i), .cnt_o(div_o)
  );

  lstb_fall_irq u_irq (
    .clk_i, .rst_ni, .cnt_i(div_o), .irq_o
  );

  // plain sample; software re-reads to reject a torn value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (re_i) rd_q <= div_o[CNT_W-1:CLR_LSB];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/lstb_checker.sv
module lstb_checker
  import lstb_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             re_i,
  input logic [RD_W-1:0]  rdata_o,
  input logic [CNT_W-1:0] div_o,
  input logic [IRQ_N-1:0] irq_o
);
  AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(we_i) && div_o != $past(div_o)) |-> div_o == $past(div_o) + 15'd1); // R2

  AST_RD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> rdata_o == $past(div_o[CNT_W-1:CLR_LSB])); // R4

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R4

  AST_WR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> div_o[CNT_W-1:CLR_LSB] == '0); // R5

  AST_IRQ128_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] |-> $past(div_o[7]) && !div_o[7]); // R6

  AST_IRQ2_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[3] |-> $past(div_o[13]) && !div_o[13]); // R6

  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |irq_o |=> (irq_o & $past(irq_o)) == '0); // R6

  AST_CLR_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && div_o[7]) |=> irq_o[0]); // R7
endmodule

bind lowspeed_timebase lstb_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i),
  .rdata_o(rdata_o), .div_o(div_o), .irq_o(irq_o)
);

// File: tb/lowspeed_timebase_bench.sv
module lowspeed_timebase_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ls = 1'b0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] rdata;
  logic [14:0] div;
  logic [3:0]  irq;

  int total = 0;
  int bad = 0;
  bit running = 0;
  bit done = 0;

  lowspeed_timebase u_lowspeed_timebase (
    .clk_i(clk), .rst_ni(rst_n), .lsclk_i(ls), .we_i(we), .re_i(re),
    .rdata_o(rdata), .div_o(div), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // slow clock: four system cycles per period
  int ls_ph = 0;
  always @(negedge clk) begin
    ls_ph <= ls_ph + 1;
    if (ls_ph % 2 == 1) ls <= ~ls;
  end

  // behavioural reference
  bit hist[$];
  int m_cnt = 0, m_prev = 0, m_rd = 0;
  bit m_wrap = 0;
  int wraps = 0;
  int tap_bit[4] = '{7, 9, 10, 13};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_cnt = 0; m_prev = 0; m_rd = 0; m_wrap = 0;
    end else begin
      bit f;
      int nxt;
      f = hist[2] && !hist[1];
      m_prev = m_cnt;
      if (re) m_rd = (m_cnt >> 7) & 255;
      if (we) nxt = (m_cnt + int'(f)) & 127;
      else    nxt = (m_cnt + int'(f)) & 32767;
      m_wrap = !we && f && m_cnt == 32767;
      void'(hist.pop_back());
      hist.push_front(ls);
      m_cnt = nxt;
    end
  end

  function automatic logic [3:0] exp_irq();
    logic [3:0] e;
    for (int i = 0; i < 4; i++)
      e[i] = ((m_prev >> tap_bit[i]) & 1) == 1 && ((m_cnt >> tap_bit[i]) & 1) == 0;
    return e;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      check(div === m_cnt[14:0], "R2/R3/R5 div", int'(div), m_cnt);
      check(irq === exp_irq(), "R6 irq", int'(irq), int'(exp_irq()));
      check(rdata === m_rd[7:0], "R4 rdata", int'(rdata), m_rd);
      if (m_wrap) begin
        wraps++;
        check(div === 15'd0, "R8 wrap", int'(div), 0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 195000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(div === '0 && irq === '0 && rdata === '0, "R1 reset", int'(div), 0);
    rst_n = 1'b1;
    running = 1;
    // mixed reads and clears
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      re <= (i % 3 == 0);
      we <= (i % 250 == 249);
    end
    @(negedge clk);
    we <= 0; re <= 0;
    // clear while 128 Hz tap is high
    while (((m_cnt >> 7) & 1) == 0) @(negedge clk);
    we <= 1;
    @(negedge clk);
    we <= 0;
    check(irq[0] === 1'b1, "R7 clear-induced irq", int'(irq), 1);
    check(div[14:7] === 8'd0, "R5 clear", int'(div), 0);
    // long run to full wrap
    for (int i = 0; i < 133000; i++) begin
      @(negedge clk);
      re <= (i % 97 == 0);
    end
    @(negedge clk);
    check(wraps > 0, "R8 wrap seen", wraps, 1);
    finish_run();
  end
endmodule